// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block sits on the controller side of a four-bank, sixteen-bit double-data-rate SDRAM. It accepts one request at a time from a user port: a read or a write to a flat word address, with an optional auto-precharge hint. It turns each request into the commands the memory needs, issued on the rising clock edge. The flat address is split into bank, row and column fields. The block records which row is open in every bank, so a hit goes straight to the column command. A miss first closes the bank, then opens the right row, then issues the column command.

A free-running down-counter raises a refresh request at a fixed interval. While that request is pending, user traffic stops. The block closes every open bank with one precharge-all command and then issues an auto-refresh. A separate configuration strobe captures a new CAS latency (2, 2.5 or 3), burst length (2, 4 or 8) and burst ordering. The block writes them to the memory with a mode-register-set command once all banks are closed. Minimum spacings are parameters counted in clocks and are enforced by one down-counter per bank: activate to column, precharge period, refresh cycle and mode-set delay.

Top module: `ddr_cmd_seq`

## Requirements
- R1: During and immediately after reset the command pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111), `req_ready` is low, and every bank is treated as closed.
- R2: The flat request address is split as bank = `req_addr[23:22]`, row = `req_addr[21:9]`, column = `req_addr[8:0]`. The row drives `ddr_a[12:0]` on activate. The column drives `ddr_a[8:0]` on read or write, and `ddr_a[12:11]` and `ddr_a[9]` are zero.
- R3: A request to a closed bank issues ACT (0011) with the bank on `ddr_ba`. The column command follows exactly T_RCD clocks later.
- R4: A request whose row matches the open row of its bank issues RD (0101) or WR (0100) with no activate. `req_ready` is high in the cycle before that command appears on the pins.
- R5: A request whose row differs from the open row issues PRE (0010) with `ddr_a[10]`=0 to that bank, then ACT no earlier than T_RP clocks later, then the column command.
- R6: `ddr_a[10]` on a column command equals `req_autopre`. After an auto-precharged column command the bank counts as closed, and the next access to that bank starts with ACT.
- R7: A refresh becomes due every REF_INTERVAL clocks and takes priority over user requests. If any bank is open, a PRE with `ddr_a[10]`=1 closes all banks first. Then REF (0001) is issued while every bank is closed.
- R8: After REF, no command reaches any bank for T_RFC clocks, and the cycle right after REF is a NOP.
- R9: A `cfg_load` pulse captures the mode inputs. Once all banks are closed, MRS (0000) is issued with `ddr_ba`=0, `ddr_a[2:0]` = burst code (001 for 2, 010 for 4, 011 for 8), `ddr_a[3]` = interleave, and `ddr_a[6:4]` = latency code (010 for 2, 110 for 2.5, 011 for 3). The `cfg_cas` select is 0/1/2 for 2/2.5/3. The `cfg_bl` select is 0/1/2 for 2/4/8.
- R10: Two column commands to the same bank are at least BL/2 clocks apart for the burst length last written by MRS (BL 4 after reset). After an auto-precharged column command, the next command to that bank waits BL/2 + T_RP clocks.
- R11: The four banks keep their open rows independently. A hit on one bank is served while the other banks stay open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every command launches on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A user request is presented |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the bank with the column command |
| req_addr | input | 24 | Flat word address {bank,row,column} |
| req_ready | output | 1 | The column command for the request launches on the next edge |
| cfg_load | input | 1 | Capture the mode inputs and schedule a mode-register write |
| cfg_cas | input | 2 | CAS latency select: 0=2, 1=2.5, 2=3 |
| cfg_bl | input | 2 | Burst length select: 0=2, 1=4, 2=8 |
| cfg_ilv | input | 1 | 1 = interleaved burst order |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | 2 | Bank select |
| ddr_a | output | 13 | Multiplexed row/column/mode address; bit 10 is the precharge flag |

## Verification
The bench aims at these corner cases:
- **Row miss.** A design that skips the precharge on a miss would read from the wrong row.
- **Refresh during traffic.** A refresh that lands while banks are open and a request is pending must not jump ahead of the precharge-all. A design that starts a refresh with a bank still open, or lets user commands slip through after the refresh is due, is caught.
- **Auto-precharge.** A design that forgets to mark the bank closed would later issue a read to a closed bank instead of a new activate.
- **Burst length change.** After a mode write changes the burst length, a design that keeps the old burst spacing or emits the wrong mode code breaks the spacing or encoding checks.

// File: rtl/ddr_seq_pkg.sv
// Package ddr_seq_pkg
// Shared command encoding and mode-field encoders for the DDR command
// sequencer. Command values are {cs_n, ras_n, cas_n, we_n}.
package ddr_seq_pkg;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } ddr_cmd_e;

    // Burst-length select (0:2, 1:4, else 8) to mode-register code.
    function automatic logic [2:0] bl_code(input logic [1:0] sel);
        case (sel)
            2'd0:    return 3'b001;
            2'd1:    return 3'b010;
            default: return 3'b011;
        endcase
    endfunction

    // CAS-latency select (0:2, 1:2.5, else 3) to mode-register code.
    function automatic logic [2:0] cas_code(input logic [1:0] sel);
        case (sel)
            2'd0:    return 3'b010;
            2'd1:    return 3'b110;
            default: return 3'b011;
        endcase
    endfunction

endpackage

// File: rtl/ddr_ref_timer.sv
// Module ddr_ref_timer
// Periodic refresh request. A down-counter reloads every INTERVAL clocks
// and sets a sticky due flag; the sequencer clears it with ack when the
// refresh command is issued. Assumes INTERVAL >= 2.
module ddr_ref_timer #(
    parameter int INTERVAL = 975
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic due
);
    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] cnt;

    // Count down, reload at zero and raise the due flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CW'(INTERVAL - 1);
            due <= 1'b0;
        end else begin
            if (ack)
                due <= 1'b0;
            if (cnt == '0) begin
                cnt <= CW'(INTERVAL - 1);
                due <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ddr_bank_slot.sv
// Module ddr_bank_slot
// State of one bank: open flag, open row, and a spacing timer. The bank
// accepts a new command only when the timer is zero. A load of N-1 makes
// the next command legal exactly N clocks after the current one.
module ddr_bank_slot #(
    parameter int ROW_W = 13,
    parameter int TW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TW-1:0]    load_val,
    input  logic             set_open,
    input  logic             clr_open,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             idle
);
    logic [TW-1:0] timer;

    // Spacing timer: load wins over the countdown.
    always_ff @(posedge clk) begin
        if (!rst_n)
            timer <= '0;
        else if (load)
            timer <= load_val;
        else if (timer != '0)
            timer <= timer - 1'b1;
    end

    // Open-row bookkeeping for this bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open  <= 1'b0;
            open_row <= '0;
        end else if (set_open) begin
            is_open  <= 1'b1;
            open_row <= row_in;
        end else if (clr_open) begin
            is_open  <= 1'b0;
        end
    end

    assign idle = (timer == '0);
endmodule

// File: rtl/ddr_mode_reg.sv
// Module ddr_mode_reg
// Holds the mode requested by the user until the sequencer writes it,
// and the active burst length that paces column commands. The active
// burst length resets to 4 (no mode write is issued at reset).
module ddr_mode_reg
    import ddr_seq_pkg::*;
#(
    parameter int A_W = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_load,
    input  logic [1:0]     cfg_cas,
    input  logic [1:0]     cfg_bl,
    input  logic           cfg_ilv,
    input  logic           mrs_done,
    output logic           pending,
    output logic [A_W-1:0] mrs_addr,
    output logic [2:0]     burst_clks
);
    logic [1:0] p_cas, p_bl, act_bl;
    logic       p_ilv;

    // Capture requested fields and track the pending write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_cas   <= 2'd0;
            p_bl    <= 2'd1;
            p_ilv   <= 1'b0;
            pending <= 1'b0;
        end else if (cfg_load) begin
            p_cas   <= cfg_cas;
            p_bl    <= cfg_bl;
            p_ilv   <= cfg_ilv;
            pending <= 1'b1;
        end else if (mrs_done) begin
            pending <= 1'b0;
        end
    end

    // The active burst length changes only when the mode write issues.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_bl <= 2'd1;
        else if (mrs_done)
            act_bl <= p_bl;
    end

    // Mode-register address image and clocks per burst.
    always_comb begin
        mrs_addr      = '0;
        mrs_addr[2:0] = bl_code(p_bl);
        mrs_addr[3]   = p_ilv;
        mrs_addr[6:4] = cas_code(p_cas);
        case (act_bl)
            2'd0:    burst_clks = 3'd1;
            2'd1:    burst_clks = 3'd2;
            default: burst_clks = 3'd4;
        endcase
    end
endmodule

// File: rtl/ddr_cmd_seq.sv
// Module ddr_cmd_seq (top)
// Turns single user requests into DDR SDRAM commands. Priority each cycle:
// due refresh, then pending mode write, then the user request. At most
// one command is chosen per cycle and it is registered onto the pins.
// Assumes COL_W < AP_BIT, T_RFC >= 2 and all spacing parameters >= 1.
// The user keeps a request stable until req_ready.
module ddr_cmd_seq
    import ddr_seq_pkg::*;
#(
    parameter int BANKS        = 4,
    parameter int ROW_W        = 13,
    parameter int COL_W        = 9,
    parameter int A_W          = 13,
    parameter int T_RCD        = 3,
    parameter int T_RP         = 3,
    parameter int T_RFC        = 10,
    parameter int T_MRD        = 2,
    parameter int REF_INTERVAL = 975,
    localparam int BA_W        = $clog2(BANKS),
    localparam int ADDR_W      = BA_W + ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_autopre,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              cfg_load,
    input  logic [1:0]        cfg_cas,
    input  logic [1:0]        cfg_bl,
    input  logic              cfg_ilv,
    output logic              ddr_cs_n,
    output logic              ddr_ras_n,
    output logic              ddr_cas_n,
    output logic              ddr_we_n,
    output logic [BA_W-1:0]   ddr_ba,
    output logic [A_W-1:0]    ddr_a
);
    localparam int AP_BIT = 10;
    localparam int TW     = $clog2(T_RFC + T_RP + T_RCD + T_MRD + 9);

    logic [BA_W-1:0]  rq_bank;
    logic [ROW_W-1:0] rq_row;
    logic [COL_W-1:0] rq_col;
    assign {rq_bank, rq_row, rq_col} = req_addr;

    logic [BANKS-1:0] open_v, idle_v, load_v, set_v, clr_v;
    logic [ROW_W-1:0] row_v [BANKS];
    logic [TW-1:0]    load_val;
    logic             ref_due, ref_ack, mode_pend, mrs_done;
    logic [A_W-1:0]   mrs_addr;
    logic [2:0]       burst_clks;
    ddr_cmd_e         nx_cmd;
    logic [BA_W-1:0]  nx_ba;
    logic [A_W-1:0]   nx_a;

    ddr_ref_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
        .clk(clk), .rst_n(rst_n), .ack(ref_ack), .due(ref_due)
    );

    ddr_mode_reg #(.A_W(A_W)) u_mode (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_cas(cfg_cas),
        .cfg_bl(cfg_bl), .cfg_ilv(cfg_ilv), .mrs_done(mrs_done),
        .pending(mode_pend), .mrs_addr(mrs_addr), .burst_clks(burst_clks)
    );

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        ddr_bank_slot #(.ROW_W(ROW_W), .TW(TW)) u_slot (
            .clk(clk), .rst_n(rst_n), .load(load_v[g]), .load_val(load_val),
            .set_open(set_v[g]), .clr_open(clr_v[g]), .row_in(rq_row),
            .is_open(open_v[g]), .open_row(row_v[g]), .idle(idle_v[g])
        );
    end

    // Choose this cycle's command and the bank-state updates it implies.
    always_comb begin
        nx_cmd    = CMD_NOP;
        nx_ba     = '0;
        nx_a      = '0;
        load_v    = '0;
        set_v     = '0;
        clr_v     = '0;
        load_val  = '0;
        ref_ack   = 1'b0;
        mrs_done  = 1'b0;
        req_ready = 1'b0;
        if (ref_due || mode_pend) begin
            if (|open_v) begin
                if (&idle_v) begin
                    nx_cmd       = CMD_PRE;
                    nx_a[AP_BIT] = 1'b1;
                    clr_v        = '1;
                    load_v       = '1;
                    load_val     = TW'(T_RP - 1);
                end
            end else if (&idle_v) begin
                load_v = '1;
                if (ref_due) begin
                    nx_cmd   = CMD_REF;
                    load_val = TW'(T_RFC - 1);
                    ref_ack  = 1'b1;
                end else begin
                    nx_cmd   = CMD_MRS;
                    nx_a     = mrs_addr;
                    load_val = TW'(T_MRD - 1);
                    mrs_done = 1'b1;
                end
            end
        end else if (req_valid && idle_v[rq_bank]) begin
            nx_ba            = rq_bank;
            load_v[rq_bank]  = 1'b1;
            if (open_v[rq_bank] && row_v[rq_bank] == rq_row) begin
                nx_cmd             = req_write ? CMD_WR : CMD_RD;
                nx_a[COL_W-1:0]    = rq_col;
                nx_a[AP_BIT]       = req_autopre;
                req_ready          = 1'b1;
                clr_v[rq_bank]     = req_autopre;
                load_val           = req_autopre ? TW'(burst_clks) + TW'(T_RP - 1)
                                                 : TW'(burst_clks) - TW'(1);
            end else if (open_v[rq_bank]) begin
                nx_cmd         = CMD_PRE;
                clr_v[rq_bank] = 1'b1;
                load_val       = TW'(T_RP - 1);
            end else begin
                nx_cmd           = CMD_ACT;
                nx_a[ROW_W-1:0]  = rq_row;
                set_v[rq_bank]   = 1'b1;
                load_val         = TW'(T_RCD - 1);
            end
        end
    end

    // Register the chosen command onto the memory pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} <= CMD_NOP;
            ddr_ba <= '0;
            ddr_a  <= '0;
        end else begin
            {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} <= nx_cmd;
            ddr_ba <= nx_ba;
            ddr_a  <= nx_a;
        end
    end
endmodule

// File: rtl/ddr_cmd_seq_chk.sv
// Module ddr_cmd_seq_chk
// Protocol checker bound to ddr_cmd_seq. Keeps its own open-bank mask,
// rebuilt only from the command pins, and checks legality against it.
module ddr_cmd_seq_chk
    import ddr_seq_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int BA_W  = 2,
    parameter int A_W   = 13
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_n,
    input logic            ras_n,
    input logic            cas_n,
    input logic            we_n,
    input logic [BA_W-1:0] ba,
    input logic [A_W-1:0]  a,
    input logic            req_ready
);
    logic [3:0]       cmd;
    logic [BANKS-1:0] open_mask;
    logic             is_col;

    assign cmd    = {cs_n, ras_n, cas_n, we_n};
    assign is_col = (cmd == CMD_RD) || (cmd == CMD_WR);

    // Rebuild open banks from the observed commands.
    always_ff @(posedge clk) begin
        if (!rst_n)
            open_mask <= '0;
        else if (cmd == CMD_ACT)
            open_mask[ba] <= 1'b1;
        else if (cmd == CMD_PRE && a[10])
            open_mask <= '0;
        else if (cmd == CMD_PRE || (is_col && a[10]))
            open_mask[ba] <= 1'b0;
    end

    assert_ready_then_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> is_col);
    assert_act_on_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |-> !open_mask[ba]);
    assert_col_on_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> open_mask[ba]);
    assert_ref_all_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |-> (open_mask == '0));
    assert_nop_after_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |=> (cmd == CMD_NOP));
    assert_mrs_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS) |-> (open_mask == '0 && a[2:0] != 3'b000 && a[2:0] != 3'b111
                              && a[2:0] != 3'b100));
endmodule

bind ddr_cmd_seq ddr_cmd_seq_chk #(.BANKS(BANKS), .BA_W(BA_W), .A_W(A_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(ddr_cs_n), .ras_n(ddr_ras_n),
    .cas_n(ddr_cas_n), .we_n(ddr_we_n), .ba(ddr_ba), .a(ddr_a),
    .req_ready(req_ready)
);

// File: tb/test_ddr_cmd_seq.sv
// Bench for ddr_cmd_seq: a behavioural memory-side model (per-bank open
// rows, last-command times, refresh schedule, request queues) judges every
// command seen on the pins, sampled on the falling clock edge.
module test_ddr_cmd_seq;
    localparam int INTV  = 400;
    localparam int T_RCD = 3;
    localparam int T_RP  = 3;
    localparam int T_RFC = 10;
    localparam int T_MRD = 2;

    logic        clk = 0, rst_n = 0;
    logic        req_valid = 0, req_write = 0, req_autopre = 0;
    logic [23:0] req_addr = '0;
    logic        req_ready;
    logic        cfg_load = 0, cfg_ilv = 0;
    logic [1:0]  cfg_cas = 0, cfg_bl = 0;
    logic        ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
    logic [1:0]  ddr_ba;
    logic [12:0] ddr_a;

    ddr_cmd_seq #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
                  .REF_INTERVAL(INTV)) i_ddr_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_autopre(req_autopre), .req_addr(req_addr), .req_ready(req_ready),
        .cfg_load(cfg_load), .cfg_cas(cfg_cas), .cfg_bl(cfg_bl), .cfg_ilv(cfg_ilv),
        .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n),
        .ddr_we_n(ddr_we_n), .ddr_ba(ddr_ba), .ddr_a(ddr_a)
    );

    always #4 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0, refs = 0;
    bit done = 0, ready_seen = 0, mpend = 0;
    int bl_clk = 2, pend_bl_clk = 2;
    logic [12:0] exp_mrs;
    bit  mopen [4];
    int  mrow [4], last_c [4], gap_c [4], lastk [4];
    int  q_bank[$], q_row[$], q_col[$], q_wr[$], q_ap[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic gap_chk(input int b);
        string tag;
        case (lastk[b])
            1: tag = "R3";
            3: tag = "R10";
            4: tag = "R8";
            5: tag = "R9";
            default: tag = "R5";
        endcase
        chk(cyc - last_c[b] >= gap_c[b], tag, cyc - last_c[b], gap_c[b]);
    endtask

    task automatic all_banks(input int kind, input int g);
        for (int i = 0; i < 4; i++) begin
            gap_chk(i);
            mopen[i] = 0; last_c[i] = cyc; gap_c[i] = g; lastk[i] = kind;
        end
    endtask

    task automatic push(input int b, input int r, input int c, input int w, input int ap);
        q_bank.push_back(b); q_row.push_back(r); q_col.push_back(c);
        q_wr.push_back(w); q_ap.push_back(ap);
    endtask

    // Monitor, model and driver, all on the falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0] cmd;
            int b, nopen, due_at;
            bit col_done;
            cyc++;
            col_done = 0;
            cmd = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};
            b = int'(ddr_ba);
            due_at = (refs + 1) * INTV;
            nopen = 0;
            for (int i = 0; i < 4; i++) nopen += int'(mopen[i]);
            if (cmd == 4'b0011 || cmd == 4'b0101 || cmd == 4'b0100 ||
                (cmd == 4'b0010 && !ddr_a[10]))
                chk(cyc <= due_at + 2, "R7", cyc, due_at);
            case (cmd)
                4'b0111: chk(!ready_seen, "R4", 0, 1);
                4'b0011: begin
                    chk(req_valid && b == q_bank[0] && !mopen[b], "R3", b, q_bank[0]);
                    chk(int'(ddr_a) == q_row[0], "R2", int'(ddr_a), q_row[0]);
                    gap_chk(b);
                    mopen[b] = 1; mrow[b] = int'(ddr_a);
                    last_c[b] = cyc; gap_c[b] = T_RCD; lastk[b] = 1;
                end
                4'b0010: begin
                    if (ddr_a[10]) begin
                        chk(mpend || cyc >= due_at - 2, "R7", cyc, due_at);
                        chk(nopen > 0, "R7", nopen, 1);
                        all_banks(2, T_RP);
                    end else begin
                        chk(req_valid && b == q_bank[0] && mopen[b] && mrow[b] != q_row[0],
                            "R5", b, q_bank[0]);
                        gap_chk(b);
                        mopen[b] = 0; last_c[b] = cyc; gap_c[b] = T_RP; lastk[b] = 2;
                    end
                end
                4'b0101, 4'b0100: begin
                    chk(ready_seen, "R4", 0, 1);
                    chk(req_valid && b == q_bank[0] && mopen[b] && mrow[b] == q_row[0],
                        nopen > 1 ? "R11" : "R4", mrow[b], q_row[0]);
                    chk(int'(cmd[0]) == 1 - q_wr[0], "R4", int'(cmd), q_wr[0] ? 4 : 5);
                    chk({ddr_a[12:11], ddr_a[9]} == 3'b0 && int'(ddr_a[8:0]) == q_col[0],
                        "R2", int'(ddr_a), q_col[0]);
                    chk(int'(ddr_a[10]) == q_ap[0], "R6", int'(ddr_a[10]), q_ap[0]);
                    if (lastk[b] == 1)
                        chk(cyc - last_c[b] == T_RCD, "R3", cyc - last_c[b], T_RCD);
                    else
                        gap_chk(b);
                    last_c[b] = cyc; lastk[b] = 3;
                    gap_c[b] = q_ap[0] ? bl_clk + T_RP : bl_clk;
                    if (q_ap[0] != 0) mopen[b] = 0;
                    col_done = 1;
                end
                4'b0001: begin
                    chk(nopen == 0, "R7", nopen, 0);
                    chk(cyc >= due_at - 2 && cyc <= due_at + 40, "R7", cyc, due_at);
                    all_banks(4, T_RFC);
                    refs++;
                end
                4'b0000: begin
                    chk(mpend && nopen == 0, "R9", nopen, 0);
                    chk(ddr_a == exp_mrs && b == 0, "R9", int'(ddr_a), int'(exp_mrs));
                    all_banks(5, T_MRD);
                    mpend = 0; bl_clk = pend_bl_clk;
                end
                default: chk(0, "R1", int'(cmd), 7);
            endcase
            if (col_done) begin
                void'(q_bank.pop_front()); void'(q_row.pop_front());
                void'(q_col.pop_front()); void'(q_wr.pop_front()); void'(q_ap.pop_front());
            end
            // Mode changes at fixed times.
            cfg_load = 0;
            if (cyc == 300) begin
                cfg_cas = 1; cfg_bl = 2; cfg_ilv = 1; cfg_load = 1; mpend = 1;
                exp_mrs = 13'h06B; pend_bl_clk = 4;
            end else if (cyc == 900) begin
                cfg_cas = 2; cfg_bl = 0; cfg_ilv = 0; cfg_load = 1; mpend = 1;
                exp_mrs = 13'h031; pend_bl_clk = 1;
            end
            // Present the head request.
            if (q_bank.size() > 0) begin
                req_valid = 1; req_write = q_wr[0][0]; req_autopre = q_ap[0][0];
                req_addr = {2'(q_bank[0]), 13'(q_row[0]), 9'(q_col[0])};
            end else begin
                req_valid = 0;
            end
            #1 ready_seen = req_ready;
        end
    end

    initial begin
        int unsigned lcg = 32'h1234_5678;
        int rows [3] = '{5, 6, 8191};
        for (int i = 0; i < 4; i++) begin
            mopen[i] = 0; mrow[i] = 0; last_c[i] = -1000; gap_c[i] = 0; lastk[i] = 0;
        end
        push(0, 5, 3, 0, 0);    // R3 closed bank
        push(0, 5, 4, 1, 0);    // R4 hit, write
        push(0, 9, 7, 0, 0);    // R5 miss
        push(1, 8191, 1, 0, 0); // R11 open the other banks
        push(2, 2, 2, 1, 0);
        push(3, 3, 511, 0, 0);
        push(1, 8191, 9, 1, 0);
        push(0, 9, 10, 0, 0);
        push(2, 2, 8, 1, 1);    // R6 auto-precharge
        push(2, 2, 9, 0, 0);
        for (int i = 0; i < 70; i++) begin
            lcg = lcg * 1103515245 + 12345;
            push(int'(lcg[17:16]), rows[lcg[20:19] % 3], int'(lcg[30:22]),
                 int'(lcg[12]), int'(lcg[5:3] == 0));
        end
        repeat (3) @(negedge clk);
        checks++;
        if ({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} !== 4'b0111 || req_ready !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: actual cmd %b ready %b expected 0111 0",
                     {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}, req_ready);
        end
        rst_n = 1;
        wait (cyc >= 1300 && q_bank.size() == 0);
        repeat (5) @(posedge clk);
        done = 1;
        chk(refs >= 3, "R7", refs, 3);
        chk(!mpend, "R9", int'(mpend), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule